// File: doc/BRIEF.md
# USB Endpoint Mode Register Pair

This block holds the per-endpoint control and status byte for two USB endpoints. Firmware and the serial interface engine (SIE) both write these bytes. Firmware uses a simple register bus that writes one whole byte and reads one back. The SIE reloads only the 4-bit mode field after it has handled a host transaction. The block reports, for each endpoint, whether an IN or an OUT token must be answered with a STALL handshake. It keeps a sticky flag that records an acknowledged transaction, and it raises an interrupt pulse for each endpoint when a transaction to that endpoint completes.

The two registers share a single update path, and the SIE always has priority on it. In any cycle where the SIE reloads either endpoint's mode, a firmware write to either register is lost entirely. Firmware therefore has to read the register back after a write and retry if the value is wrong. An acknowledged completion sets the sticky flag. Any firmware write that is actually applied clears that flag, whatever value is written to bit 4.

Top module: `ep_mode_regfile`

## Requirements
- R1: While reset (rstN low) is asserted, both registers read 0x00, and stallIn, stallOut and epIrq are all 0.
- R2: rdData is the register selected by fwSel (0 = first endpoint, 1 = second endpoint). The byte layout is: bit 7 stall flag, bit 6 always 0, bit 5 NAK-interrupt enable, bit 4 acknowledged flag, bits 3:0 mode.
- R3: An applied firmware write copies fwWdata bits 7, 5 and 3:0 into the selected register at the next clock edge. fwWdata bit 6 has no effect.
- R4: An applied firmware write clears the acknowledged flag of the selected register, whatever the value of fwWdata bit 4.
- R5: When txnDone is high and txnResult is 0 (ACK), the acknowledged flag of the endpoint named by txnEp reads 1 after the clock edge. This holds even if a firmware write to that register is applied in the same cycle. The txnResult encoding is 0 ACK, 1 NAK, 2 STALL.
- R6: The mode encoding is 0 disabled, 1 NAK-IN, 2 ACK-IN, 3 NAK-OUT, 4 ACK-OUT, and 5 to 15 NAK-all. stallIn[e] is 1 exactly when endpoint e has its stall flag set and mode 2. stallOut[e] is 1 exactly when endpoint e has its stall flag set and mode 4. In every other mode the stall flag is ignored.
- R7: A completion with result ACK makes epIrq[txnEp] high for exactly the one cycle that follows the edge.
- R8: A completion with result NAK raises epIrq[txnEp] only if that endpoint's NAK-interrupt enable bit is 1 when the completion is sampled.
- R9: When sieWrEn[e] is high, endpoint e's mode is loaded from sieMode[4e+3:4e] and its other fields are unchanged. A firmware write to the same register in that cycle is discarded.
- R10: When any bit of sieWrEn is high, a firmware write to the other register in the same cycle is discarded completely. Its fields and its acknowledged flag are unchanged.
- R11: A completion with result STALL neither raises an interrupt nor sets the acknowledged flag. With txnDone low, epIrq stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fwWrEn | input | 1 | Firmware write strobe |
| fwSel | input | 1 | Firmware register select, also selects the byte shown on rdData |
| fwWdata | input | 8 | Firmware write data |
| rdData | output | 8 | Read-back of the selected register |
| sieWrEn | input | 2 | SIE mode reload strobe, one bit per endpoint |
| sieMode | input | 8 | SIE new modes, endpoint e in bits 4e+3:4e |
| txnDone | input | 1 | A transaction has completed this cycle |
| txnEp | input | 1 | Endpoint of the completed transaction |
| txnResult | input | 2 | Handshake of the completion: 0 ACK, 1 NAK, 2 STALL |
| stallIn | output | 2 | Per endpoint: answer IN tokens with STALL |
| stallOut | output | 2 | Per endpoint: answer OUT tokens with STALL |
| epIrq | output | 2 | Per endpoint interrupt pulse |

## Verification
The bench targets several same-cycle collisions:
- An ACK completion that coincides with a firmware write to the same register. A design that lets the write win loses the acknowledged flag.
- An SIE reload on one endpoint together with a firmware write to the other. A design with separate update paths would wrongly apply that firmware write.
- An SIE reload and a firmware write on the same endpoint. Here firmware must not win.

It also covers the stall flag set with each mode, including the NAK-all codes, where a loose decode would stall the wrong direction. Finally, it covers NAK completions with the enable bit clear, where a careless interrupt path would still pulse.

// File: rtl/ep_mode_pkg.sv
package ep_mode_pkg;
  localparam int EP_COUNT = 2;
  localparam int SEL_W = (EP_COUNT > 1) ? $clog2(EP_COUNT) : 1;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_DISABLED = 4'd0;
  localparam logic [MODE_W-1:0] MODE_NAK_IN   = 4'd1;
  localparam logic [MODE_W-1:0] MODE_ACK_IN   = 4'd2;
  localparam logic [MODE_W-1:0] MODE_NAK_OUT  = 4'd3;
  localparam logic [MODE_W-1:0] MODE_ACK_OUT  = 4'd4;

  localparam logic [1:0] RES_ACK   = 2'd0;
  localparam logic [1:0] RES_NAK   = 2'd1;
  localparam logic [1:0] RES_STALL = 2'd2;

  typedef struct packed {
    logic             stall;
    logic             nakIe;
    logic             ackSeen;
    logic [MODE_W-1:0] mode;
  } epState_t;

  typedef struct packed {
    logic [EP_COUNT-1:0] fwLoad;
    logic [EP_COUNT-1:0] sieLoad;
    logic [EP_COUNT-1:0] ackSet;
  } epStrobe_t;
endpackage

// File: rtl/ep_mode_ctrl.sv
module ep_mode_ctrl
  import ep_mode_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                fwWrEn,
  input  logic [SEL_W-1:0]    fwSel,
  input  logic [EP_COUNT-1:0] sieWrEn,
  input  logic                txnDone,
  input  logic [SEL_W-1:0]    txnEp,
  input  logic [1:0]          txnResult,
  input  logic [EP_COUNT-1:0] nakIeVec,
  output epStrobe_t           strobes,
  output logic [EP_COUNT-1:0] epIrq
);
  // One shared update path: any SIE reload blocks every firmware write.
  logic sieBusy;
  logic fwGrant;
  logic [EP_COUNT-1:0] irqNext;

  assign sieBusy = |sieWrEn;
  assign fwGrant = fwWrEn && !sieBusy;

  for (genvar e = 0; e < EP_COUNT; e++) begin : g_ep
    logic hit;
    assign hit = txnDone && (txnEp == SEL_W'(e));
    assign strobes.sieLoad[e] = sieWrEn[e];
    assign strobes.fwLoad[e]  = fwGrant && (fwSel == SEL_W'(e));
    assign strobes.ackSet[e]  = hit && (txnResult == RES_ACK);
    assign irqNext[e] = hit && ((txnResult == RES_ACK) ||
                                ((txnResult == RES_NAK) && nakIeVec[e]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) epIrq <= '0;
    else       epIrq <= irqNext;
  end
endmodule

// File: rtl/ep_mode_datapath.sv
module ep_mode_datapath
  import ep_mode_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  epStrobe_t                  strobes,
  input  logic [7:0]                 fwWdata,
  input  logic [SEL_W-1:0]           fwSel,
  input  logic [MODE_W*EP_COUNT-1:0] sieMode,
  output logic [7:0]                 rdData,
  output logic [EP_COUNT-1:0]        stallIn,
  output logic [EP_COUNT-1:0]        stallOut,
  output logic [EP_COUNT-1:0]        nakIeVec
);
  epState_t epReg [EP_COUNT];

  for (genvar e = 0; e < EP_COUNT; e++) begin : g_ep
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        epReg[e] <= '0;
      end else begin
        if (strobes.sieLoad[e]) begin
          epReg[e].mode <= sieMode[e*MODE_W +: MODE_W];
        end else if (strobes.fwLoad[e]) begin
          epReg[e].stall <= fwWdata[7];
          epReg[e].nakIe <= fwWdata[5];
          epReg[e].mode  <= fwWdata[MODE_W-1:0];
        end
        // A completion's set outranks the clear caused by a firmware write.
        if (strobes.ackSet[e])      epReg[e].ackSeen <= 1'b1;
        else if (strobes.fwLoad[e]) epReg[e].ackSeen <= 1'b0;
      end
    end

    assign stallIn[e]  = epReg[e].stall && (epReg[e].mode == MODE_ACK_IN);
    assign stallOut[e] = epReg[e].stall && (epReg[e].mode == MODE_ACK_OUT);
    assign nakIeVec[e] = epReg[e].nakIe;
  end

  epState_t selReg;
  always_comb begin
    selReg = '0;
    for (int e = 0; e < EP_COUNT; e++)
      if (fwSel == SEL_W'(e)) selReg = epReg[e];
  end

  assign rdData = {selReg.stall, 1'b0, selReg.nakIe, selReg.ackSeen, selReg.mode};
endmodule

// File: rtl/ep_mode_regfile.sv
module ep_mode_regfile
  import ep_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fwWrEn,
  input  logic        fwSel,
  input  logic [7:0]  fwWdata,
  output logic [7:0]  rdData,
  input  logic [1:0]  sieWrEn,
  input  logic [7:0]  sieMode,
  input  logic        txnDone,
  input  logic        txnEp,
  input  logic [1:0]  txnResult,
  output logic [1:0]  stallIn,
  output logic [1:0]  stallOut,
  output logic [1:0]  epIrq
);
  epStrobe_t strobes;
  logic [EP_COUNT-1:0] nakIeVec;

  ep_mode_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fwWrEn(fwWrEn), .fwSel(fwSel),
    .sieWrEn(sieWrEn), .txnDone(txnDone), .txnEp(txnEp),
    .txnResult(txnResult), .nakIeVec(nakIeVec),
    .strobes(strobes), .epIrq(epIrq)
  );

  ep_mode_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .fwWdata(fwWdata),
    .fwSel(fwSel), .sieMode(sieMode), .rdData(rdData),
    .stallIn(stallIn), .stallOut(stallOut), .nakIeVec(nakIeVec)
  );
endmodule

// File: rtl/ep_mode_checker.sv
module ep_mode_checker (
  input logic       clk,
  input logic       rstN,
  input logic       fwWrEn,
  input logic       fwSel,
  input logic [7:0] fwWdata,
  input logic [7:0] rdData,
  input logic [1:0] sieWrEn,
  input logic [7:0] sieMode,
  input logic       txnDone,
  input logic       txnEp,
  input logic [1:0] txnResult,
  input logic [1:0] stallIn,
  input logic [1:0] stallOut,
  input logic [1:0] epIrq
);
  logic [3:0] selSieMode;
  logic       ackHitSel;
  assign selSieMode = fwSel ? sieMode[7:4] : sieMode[3:0];
  assign ackHitSel  = txnDone && (txnResult == 2'd0) && (txnEp == fwSel);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[6] == 1'b0);

  assert_stall_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stallIn & stallOut) == 2'b00);

  assert_fw_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fwWrEn && sieWrEn == 2'b00) |=>
      (fwSel != $past(fwSel)) ||
      (rdData[7] == $past(fwWdata[7]) && rdData[5] == $past(fwWdata[5]) &&
       rdData[3:0] == $past(fwWdata[3:0])));

  assert_fw_clears_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fwWrEn && sieWrEn == 2'b00 && !ackHitSel) |=>
      (fwSel != $past(fwSel)) || !rdData[4]);

  assert_ack_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    ackHitSel |=> (fwSel != $past(fwSel)) || rdData[4]);

  assert_ack_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txnDone && txnResult == 2'd0) |=> epIrq[$past(txnEp)]);

  assert_irq_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(epIrq));

  assert_nak_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txnDone && txnResult == 2'd1 && txnEp == fwSel && !rdData[5]) |=> epIrq == 2'b00);

  assert_sie_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    sieWrEn[fwSel] |=> (fwSel != $past(fwSel)) || rdData[3:0] == $past(selSieMode));

  assert_fw_dropped_R10: assert property (@(posedge clk) disable iff (!rstN)
    (fwWrEn && sieWrEn != 2'b00 && !sieWrEn[fwSel]) |=>
      (fwSel != $past(fwSel)) ||
      (rdData[7:5] == $past(rdData[7:5]) && rdData[3:0] == $past(rdData[3:0])));

  assert_quiet_irq_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!txnDone || txnResult == 2'd2) |=> epIrq == 2'b00);
endmodule

bind ep_mode_regfile ep_mode_checker u_chk (
  .clk(clk), .rstN(rstN), .fwWrEn(fwWrEn), .fwSel(fwSel), .fwWdata(fwWdata),
  .rdData(rdData), .sieWrEn(sieWrEn), .sieMode(sieMode), .txnDone(txnDone),
  .txnEp(txnEp), .txnResult(txnResult), .stallIn(stallIn),
  .stallOut(stallOut), .epIrq(epIrq)
);

// File: tb/ep_mode_regfile_test.sv
`timescale 1ns/1ps
module ep_mode_regfile_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fwWrEn = 1'b0;
  logic       fwSel = 1'b0;
  logic [7:0] fwWdata = '0;
  logic [7:0] rdData;
  logic [1:0] sieWrEn = '0;
  logic [7:0] sieMode = '0;
  logic       txnDone = 1'b0;
  logic       txnEp = 1'b0;
  logic [1:0] txnResult = '0;
  logic [1:0] stallIn, stallOut, epIrq;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // Bench model of the two registers
  logic       mStall [2];
  logic       mNak   [2];
  logic       mAck   [2];
  logic [3:0] mMode  [2];
  logic [1:0] mIrq;

  always #10 clk = ~clk;  // 50 MHz

  ep_mode_regfile uut (
    .clk(clk), .rstN(rstN), .fwWrEn(fwWrEn), .fwSel(fwSel), .fwWdata(fwWdata),
    .rdData(rdData), .sieWrEn(sieWrEn), .sieMode(sieMode), .txnDone(txnDone),
    .txnEp(txnEp), .txnResult(txnResult), .stallIn(stallIn),
    .stallOut(stallOut), .epIrq(epIrq)
  );

  function automatic logic [7:0] expByte(input int e);
    return {mStall[e], 1'b0, mNak[e], mAck[e], mMode[e]};
  endfunction

  function automatic logic expStallIn(input int e);
    return mStall[e] && (mMode[e] == 4'd2);
  endfunction

  function automatic logic expStallOut(input int e);
    return mStall[e] && (mMode[e] == 4'd4);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic verifyAll();
    for (int e = 0; e < 2; e++) begin
      fwSel = e[0];
      #1;
      check("R2 R3 R4 R5 R9 R10 register readback", rdData, expByte(e));
      check("R6 stallIn decode", {7'd0, stallIn[e]}, {7'd0, expStallIn(e)});
      check("R6 stallOut decode", {7'd0, stallOut[e]}, {7'd0, expStallOut(e)});
      check("R7 R8 R11 interrupt pulse", {7'd0, epIrq[e]}, {7'd0, mIrq[e]});
    end
  endtask

  task automatic runCycle(input logic fwWe, input logic sel, input logic [7:0] wd,
                          input logic [1:0] sie, input logic [3:0] m0, input logic [3:0] m1,
                          input logic done, input logic ep, input logic [1:0] res);
    logic [3:0] sm [2];
    logic fwOk;
    fwWrEn = fwWe; fwSel = sel; fwWdata = wd;
    sieWrEn = sie; sieMode = {m1, m0};
    txnDone = done; txnEp = ep; txnResult = res;
    sm[0] = m0; sm[1] = m1;
    fwOk = fwWe && (sie == 2'b00);
    for (int e = 0; e < 2; e++) begin
      mIrq[e] = done && (ep == e[0]) && ((res == 2'd0) || (res == 2'd1 && mNak[e]));
    end
    @(posedge clk);
    @(negedge clk);
    fwWrEn = 1'b0; sieWrEn = 2'b00; txnDone = 1'b0;
    for (int e = 0; e < 2; e++) begin
      if (sie[e]) begin
        mMode[e] = sm[e];
      end else if (fwOk && sel == e[0]) begin
        mStall[e] = wd[7]; mNak[e] = wd[5]; mMode[e] = wd[3:0];
      end
      if (done && ep == e[0] && res == 2'd0) mAck[e] = 1'b1;
      else if (fwOk && sel == e[0]) mAck[e] = 1'b0;
    end
    verifyAll();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int e = 0; e < 2; e++) begin
      mStall[e] = 0; mNak[e] = 0; mAck[e] = 0; mMode[e] = '0;
    end
    mIrq = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int e = 0; e < 2; e++) begin
      fwSel = e[0];
      #1;
      check("R1 reset readback", rdData, 8'h00);
      check("R1 reset outputs", {2'b00, stallIn, stallOut, epIrq}, 8'h00);
    end
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Directed corners
    runCycle(1, 0, 8'hA2, 2'b00, 0, 0, 0, 0, 0);       // R6 stall with ACK-IN
    runCycle(1, 1, 8'h84, 2'b00, 0, 0, 0, 0, 0);       // R6 stall with ACK-OUT
    runCycle(1, 0, 8'h22, 2'b00, 0, 0, 1, 0, 2'd0);    // R5 set beats clear
    runCycle(1, 0, 8'hFF, 2'b00, 0, 0, 0, 0, 0);       // R4 clear, bit6 ignored, NAK-all
    runCycle(1, 0, 8'h83, 2'b10, 0, 4'd4, 0, 0, 0);    // R10 fw to other reg dropped
    runCycle(1, 1, 8'h01, 2'b10, 0, 4'd2, 0, 0, 0);    // R9 SIE wins same reg
    runCycle(0, 0, 8'h00, 2'b00, 0, 0, 1, 1, 2'd1);    // R8 NAK with enable low
    runCycle(0, 0, 8'h00, 2'b00, 0, 0, 1, 0, 2'd1);    // R8 NAK with enable high
    runCycle(0, 0, 8'h00, 2'b00, 0, 0, 1, 1, 2'd2);    // R11 STALL result
    runCycle(0, 0, 8'h00, 2'b00, 0, 0, 1, 1, 2'd0);    // R7 ACK pulse
    runCycle(0, 0, 8'h00, 2'b00, 0, 0, 0, 0, 0);       // R7 pulse ends

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] wd;
      logic [1:0] sie;
      logic [3:0] m0, m1;
      wd = 8'($urandom);
      if ($urandom % 4 != 0) wd[3:0] = 4'($urandom % 5);
      sie = ($urandom % 5 == 0) ? 2'($urandom) : 2'b00;
      m0 = ($urandom % 4 != 0) ? 4'($urandom % 5) : 4'($urandom);
      m1 = ($urandom % 4 != 0) ? 4'($urandom % 5) : 4'($urandom);
      runCycle(($urandom % 3) == 0, 1'($urandom), wd, sie, m0, m1,
               1'($urandom), 1'($urandom), 2'($urandom % 3));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule